// File: doc/BRIEF.md
# Phantom Read Sweep Evictor

This block empties one private set-associative cache with true-LRU replacement, and it never issues an invalidate command. Each set receives one read per way, and each read carries a different tag. Every address in the sweep lies in a phantom region above the top of the workload's memory. After the last read of a set, each line that normal execution brought into that set has been replaced in the ordinary way. The cache's usual victim path handles the evicted data and keeps it coherent. This block has no part in that.

A start pulse gives the block the requesting processor's ID and the base of the phantom area. Each processor gets its own slice of that area, selected by its ID, so two processors never read the same phantom line. The block walks the sets from first to last and sends its requests on a valid/ready port. When the final request has been accepted, it raises a one-cycle completion pulse. The result is not a true invalidation: afterwards the cache holds only phantom lines and nothing the workload touched.

Top module: `lru_sweep_evictor`

## Requirements
- R1: After reset, `req_valid_o` and `done_o` are both low.
- R2: A start is accepted when `start_i` is high at a clock edge while the block is idle and the base passes the range check. `req_valid_o` is then high from the next cycle on, carrying the address for set 0, way 0.
- R3: Every request address equals `base + cpu_id*2^(OFF+SW+WW) + way*2^(OFF+SW) + set*2^OFF`. OFF is log2 of the block size, SW is the width of the set index and WW is the width of the way counter. The OFF low bits are therefore zero, and processors with different IDs get disjoint regions.
- R4: The way counter is the inner loop (0 to WAYS-1) and the set is the outer loop (0 to NUM_SETS-1). A sweep issues exactly WAYS*NUM_SETS requests.
- R5: The sweep moves forward only on an edge where `req_valid_o` and `req_ready_i` are both high. While `req_ready_i` is low, `req_valid_o` stays high and `req_addr_o` does not change.
- R6: `done_o` is high for exactly the one cycle after the final request is accepted. `req_valid_o` is low in that cycle.
- R7: A start pulse that arrives during a sweep has no effect. The sweep in progress keeps its base, its ID and its sequence.
- R8: A start whose base is below 2^MEM_LOG2 is ignored. No request and no `done_o` follow.
- R9: A start is ignored if `base + 2^(CPU_W+OFF+SW+WW)` exceeds 2^ADDR_W, meaning the regions of all processor IDs would not fit in the address space. A base exactly at that limit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a sweep |
| cpu_id_i | input | CPU_W | ID of the processor that owns the cache |
| region_base_i | input | ADDR_W | Base of the phantom area |
| req_valid_o | output | 1 | Request valid |
| req_addr_o | output | ADDR_W | Phantom read address |
| req_ready_i | input | 1 | Cache accepts the request |
| done_o | output | 1 | One-cycle pulse after the last request is accepted |

## Verification
The bench builds the block with 4 sets, 4 ways, 64-byte blocks, a 40-bit address, 2 bits of processor ID and a memory top of 2^32. With these values a full sweep is only 16 requests. This makes it practical to run several sweeps, with ready always high and with ready toggling. It also puts both range limits within reach: a base just under the memory top, and bases exactly at and just over the upper fit limit, where the highest processor ID reaches the last address.

// File: rtl/lru_sweep_pkg.sv
package lru_sweep_pkg;
  typedef enum logic [0:0] {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sweep_state_t;

  function automatic int unsigned field_w(input int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/lru_sweep_guard.sv
module lru_sweep_guard #(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned MEM_LOG2   = 32,
  parameter int unsigned REGION_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] base_i,
  output logic              base_ok_o
);
  localparam logic [ADDR_W:0] MEM_TOP   = (ADDR_W+1)'(1) << MEM_LOG2;
  localparam logic [ADDR_W:0] ADDR_TOP  = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] ALL_SPAN  = (ADDR_W+1)'(1) << REGION_LOG2;

  function automatic logic region_fits(input logic [ADDR_W-1:0] b);
    logic [ADDR_W:0] lo;
    logic [ADDR_W:0] hi;
    lo = {1'b0, b};
    hi = lo + ALL_SPAN;
    return (lo >= MEM_TOP) && (hi <= ADDR_TOP);
  endfunction

  assign base_ok_o = region_fits(base_i);
endmodule

// File: rtl/lru_sweep_cnt.sv
module lru_sweep_cnt #(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned WAYS     = 4,
  parameter int unsigned SET_W    = 6,
  parameter int unsigned WAY_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [SET_W-1:0] set_o,
  output logic [WAY_W-1:0] way_o,
  output logic             last_o
);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(NUM_SETS - 1);
  localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

  logic way_wrap;
  assign way_wrap = (way_o == WAY_LAST);
  assign last_o   = way_wrap && (set_o == SET_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      set_o <= '0;
      way_o <= '0;
    end else if (step_i) begin
      if (way_wrap) begin
        way_o <= '0;
        set_o <= last_o ? '0 : set_o + 1'b1;
      end else begin
        way_o <= way_o + 1'b1;
      end
    end
  end

  // R4
  way_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && way_o == WAY_LAST) |=> (way_o == '0));

  // R4
  set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && way_o != WAY_LAST) |=> $stable(set_o));
endmodule

// File: rtl/lru_sweep_addr.sv
module lru_sweep_addr #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned CPU_W  = 2,
  parameter int unsigned SET_W  = 6,
  parameter int unsigned WAY_W  = 2,
  parameter int unsigned OFF_W  = 6
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CPU_W-1:0]  cpu_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned SET_SH = OFF_W;
  localparam int unsigned WAY_SH = OFF_W + SET_W;
  localparam int unsigned CPU_SH = OFF_W + SET_W + WAY_W;

  function automatic logic [ADDR_W-1:0] compose(
    input logic [ADDR_W-1:0] b,
    input logic [CPU_W-1:0]  c,
    input logic [SET_W-1:0]  s,
    input logic [WAY_W-1:0]  w
  );
    logic [ADDR_W-1:0] off;
    off = (ADDR_W'(c) << CPU_SH) | (ADDR_W'(w) << WAY_SH) | (ADDR_W'(s) << SET_SH);
    return b + off;
  endfunction

  assign addr_o = compose(base_i, cpu_i, set_i, way_i);
endmodule

// File: rtl/lru_sweep_evictor.sv
module lru_sweep_evictor #(
  parameter int unsigned NUM_SETS    = 64,
  parameter int unsigned WAYS        = 4,
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned ADDR_W      = 40,
  parameter int unsigned MEM_LOG2    = 32,
  parameter int unsigned CPU_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CPU_W-1:0]  cpu_id_i,
  input  logic [ADDR_W-1:0] region_base_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              req_ready_i,
  output logic              done_o
);
  import lru_sweep_pkg::*;

  localparam int unsigned SET_W       = field_w(NUM_SETS);
  localparam int unsigned WAY_W       = field_w(WAYS);
  localparam int unsigned OFF_W       = $clog2(BLOCK_BYTES);
  localparam int unsigned REGION_LOG2 = CPU_W + OFF_W + SET_W + WAY_W;

  sweep_state_t      state_q;
  logic [ADDR_W-1:0] base_q;
  logic [CPU_W-1:0]  cpu_q;
  logic              done_q;
  logic [SET_W-1:0]  set_idx;
  logic [WAY_W-1:0]  way_idx;
  logic              last_req;
  logic              base_ok;
  logic              start_take;
  logic              req_fire;
  logic              sweep_end;

  lru_sweep_guard #(
    .ADDR_W     (ADDR_W),
    .MEM_LOG2   (MEM_LOG2),
    .REGION_LOG2(REGION_LOG2)
  ) u_guard (
    .base_i   (region_base_i),
    .base_ok_o(base_ok)
  );

  assign start_take = (state_q == SW_IDLE) && start_i && base_ok;
  assign req_fire   = (state_q == SW_RUN) && req_ready_i;
  assign sweep_end  = req_fire && last_req;

  lru_sweep_cnt #(
    .NUM_SETS(NUM_SETS),
    .WAYS    (WAYS),
    .SET_W   (SET_W),
    .WAY_W   (WAY_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(start_take),
    .step_i (req_fire),
    .set_o  (set_idx),
    .way_o  (way_idx),
    .last_o (last_req)
  );

  lru_sweep_addr #(
    .ADDR_W(ADDR_W),
    .CPU_W (CPU_W),
    .SET_W (SET_W),
    .WAY_W (WAY_W),
    .OFF_W (OFF_W)
  ) u_addr (
    .base_i(base_q),
    .cpu_i (cpu_q),
    .set_i (set_idx),
    .way_i (way_idx),
    .addr_o(req_addr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      base_q  <= '0;
      cpu_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= sweep_end;
      if (start_take) begin
        state_q <= SW_RUN;
        base_q  <= region_base_i;
        cpu_q   <= cpu_id_i;
      end else if (sweep_end) begin
        state_q <= SW_IDLE;
      end
    end
  end

  assign req_valid_o = (state_q == SW_RUN);
  assign done_o      = done_q;

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(req_valid_o && req_ready_i && last_req) && !req_valid_o));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i && start_i) |=> $stable(req_addr_o));

  // R8
  range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid_o && start_i && !base_ok) |=> !req_valid_o);

  // R3
  block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_addr_o[OFF_W-1:0] == '0));
endmodule

// File: tb/lru_sweep_evictor_tb.sv
module lru_sweep_evictor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS  = 4;
  localparam int NWAYS  = 4;
  localparam int BLK    = 64;
  localparam int AW     = 40;
  localparam int MLOG   = 32;
  localparam int CW     = 2;
  localparam int TOTAL  = NSETS * NWAYS;
  localparam longint CPU_STRIDE = longint'(BLK) * NSETS * NWAYS;
  localparam longint ALL_SPAN   = CPU_STRIDE << CW;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [CW-1:0] cpu = '0;
  logic [AW-1:0] base = '0;
  logic ready = 1;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic done;

  int checks = 0;
  int fails = 0;
  int ready_mode = 0;
  int cyc = 0;
  int fired = 0;

  bit m_run = 0;
  bit m_done = 0;
  int m_idx = 0;
  longint m_base = 0;
  longint m_cpu = 0;
  longint acc_q[$];

  lru_sweep_evictor #(
    .NUM_SETS(NSETS), .WAYS(NWAYS), .BLOCK_BYTES(BLK),
    .ADDR_W(AW), .MEM_LOG2(MLOG), .CPU_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cpu_id_i(cpu),
    .region_base_i(base), .req_valid_o(req_valid), .req_addr_o(req_addr),
    .req_ready_i(ready), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit base_fits(longint b);
    return (b >= (longint'(1) << MLOG)) && (b + ALL_SPAN <= (longint'(1) << AW));
  endfunction

  function automatic longint want_addr(longint b, longint c, int idx);
    return b + c * CPU_STRIDE + longint'(idx % NWAYS) * (BLK * NSETS)
             + longint'(idx / NWAYS) * BLK;
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run <= 0; m_done <= 0; m_idx <= 0;
    end else begin
      m_done <= 0;
      if (m_run) begin
        if (ready) begin
          acc_q.push_back(want_addr(m_base, m_cpu, m_idx));
          if (m_idx == TOTAL - 1) begin
            m_run <= 0; m_done <= 1;
          end else m_idx <= m_idx + 1;
        end
      end else if (start && base_fits(longint'(base))) begin
        m_run <= 1; m_idx <= 0; m_base <= longint'(base); m_cpu <= longint'(cpu);
      end
    end
    if (rst_n && req_valid && ready) fired++;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (rst_n) begin
      check(req_valid == m_run, "R2 R5 R7 R8 req_valid", longint'(req_valid), longint'(m_run));
      check(done == m_done, "R6 done", longint'(done), longint'(m_done));
      if (m_run)
        check(longint'(req_addr) == want_addr(m_base, m_cpu, m_idx),
              "R3 R4 req_addr", longint'(req_addr), want_addr(m_base, m_cpu, m_idx));
    end
  end

  task automatic pulse_start(longint b, int c);
    @(negedge clk);
    base = AW'(b); cpu = CW'(c); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((m_run || m_done) && n < 500) begin
      @(negedge clk); n++;
    end
    @(negedge clk);
  endtask

  task automatic sweep(longint b, int c, string tag);
    fired = 0;
    acc_q.delete();
    pulse_start(b, c);
    wait_idle();
    check(fired == TOTAL, {tag, " R4 request count"}, fired, TOTAL);
    check(acc_q.size() == TOTAL, {tag, " R4 model count"}, acc_q.size(), TOTAL);
    if (acc_q.size() == TOTAL)
      check(acc_q[TOTAL-1] == b + c * CPU_STRIDE + CPU_STRIDE - BLK,
            {tag, " R3 final address"}, acc_q[TOTAL-1], b + c * CPU_STRIDE + CPU_STRIDE - BLK);
  endtask

  task automatic reject(longint b, string tag);
    fired = 0;
    pulse_start(b, 1);
    repeat (4) @(negedge clk);
    check(fired == 0 && !req_valid && !done, tag, fired, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!req_valid && !done, "R1 reset outputs", {req_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!req_valid && !done, "R1 idle after reset", {req_valid, done}, 0);

    // R2 R4: ready always high
    ready_mode = 0;
    sweep(longint'(1) << 32, 1, "sweep1");

    // R5 R7: stalls, and a start pulse during the sweep
    ready_mode = 1;
    fired = 0;
    acc_q.delete();
    pulse_start(longint'(1) << 33, 3);
    repeat (3) @(negedge clk);
    pulse_start(longint'(1) << 34, 0);
    wait_idle();
    check(fired == TOTAL, "R7 request count with busy start", fired, TOTAL);
    if (acc_q.size() == TOTAL)
      check(acc_q[0] == (longint'(1) << 33) + 3 * CPU_STRIDE,
            "R7 first address keeps original base", acc_q[0], (longint'(1) << 33) + 3 * CPU_STRIDE);

    // R8: base below memory top
    reject((longint'(1) << 32) - BLK, "R8 low base ignored");

    // R9: exact upper fit accepted, just over rejected
    sweep((longint'(1) << AW) - ALL_SPAN, 3, "R9 top fit");
    reject((longint'(1) << AW) - ALL_SPAN + BLK, "R9 overflow ignored");

    // R3: a different ID gives a disjoint region
    ready_mode = 0;
    sweep(longint'(1) << 32, 0, "sweep cpu0");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule